// File: doc/BRIEF.md
# USB Device Control Register and Handshake Arbiter

This block holds the software-writable control word of a USB device controller and decides, for every transaction the link layer reports, which handshake the device answers with. Software loads the word through a simple write port and can read it back at any time. The stored fields drive the speed selection, four transceiver test selects, the pull-up enable and an upstream-resume request toward the link layer.

The link layer gives a one-cycle transaction strobe together with the token kind, the endpoint number and whether that endpoint's buffer bank is ready. One clock later the block presents a handshake strobe and code. Two control fields override normal handshaking: a global NAK switch, and a no-reply switch that silences endpoint 0 for everything except SETUP. Hardware events clear fields on their own: a SETUP clears the no-reply switch, and a USB reset or a resume-done event ends the resume request. When a hardware clear and a software write hit the same bit in one cycle, the clear wins.

Two small state machines do the sequencing. The resume machine has states RSM_IDLE and RSM_SIGNAL: a write of 1 to the resume bit moves RSM_IDLE to RSM_SIGNAL (unless a clear event arrives that cycle); bus reset or resume-done moves RSM_SIGNAL back to RSM_IDLE; otherwise the state holds. The reply machine has states ARB_IDLE and ARB_REPLY: a transaction strobe moves it to ARB_REPLY for the next cycle (back-to-back strobes keep it there), and a cycle without a strobe returns it to ARB_IDLE.

Top module: `usbd_ctrl_hsk`

## Requirements
- R1: After reset the read-back word is 0x0001, pullup_en is 0, resume_req is 0 and hsk_valid is 0.
- R2: A write loads bit fields: [11:10] LPM answer mode, [9] global NAK, [8] no-stuff/no-NRZI test, [7] test-packet, [6] test-K, [5] test-J, [4] no-reply, [3:2] speed (0 full, 1 low, 2 high capable, 3 forced high test), [0] detach; bits 15:12 read 0; speed_cfg, tm_nostuff, tm_packet, tm_k, tm_j follow their bits and pullup_en is the inverse of bit 0, all from the cycle after the write.
- R3: Token codes are SETUP=0, IN=1, OUT=2, LPM=3 and handshake codes NONE=0, ACK=1, NAK=2, NYET=3; with no override active a SETUP, IN or OUT transaction is answered ACK when bank_ready is 1 and NAK when it is 0.
- R4: With bit 9 set, every transaction not ignored under R5 is answered NAK, regardless of bank_ready and token kind.
- R5: With bit 4 set, any non-SETUP transaction to endpoint 0 is answered NONE; transactions to other endpoints and SETUP to endpoint 0 are handled as if bit 4 were clear.
- R6: A SETUP transaction clears bit 4 from the next cycle on, even if software writes 1 to it in the same cycle.
- R7: An LPM transaction not covered by R4 or R5 is answered by bits 11:10: 1 gives ACK, 2 gives NYET, 0 and 3 give NONE.
- R8: Writing 1 to bit 1 raises resume_req from the next cycle; it stays high until bus_reset or resume_done, which clear it from the next cycle and win over a simultaneous write; writing 0 to bit 1 has no effect; read-back bit 1 equals resume_req.
- R9: hsk_valid is high exactly in the cycle after a cycle with txn_valid high, and the answer uses the control word as it stood in the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Control word write value |
| rd_data | output | DATA_W | Control word read-back |
| txn_valid | input | 1 | Transaction strobe from link layer |
| txn_token | input | 2 | Token kind of the transaction |
| txn_ep | input | EP_W | Endpoint number of the transaction |
| bank_ready | input | 1 | Endpoint buffer bank ready |
| bus_reset | input | 1 | USB reset event |
| resume_done | input | 1 | Upstream resume has been sent |
| hsk_valid | output | 1 | Handshake decision strobe |
| hsk_code | output | 2 | Handshake decision code |
| speed_cfg | output | 2 | Speed configuration |
| tm_nostuff | output | 1 | Bit-stuffing/NRZI disable test select |
| tm_packet | output | 1 | Test packet select |
| tm_k | output | 1 | High-speed K test select |
| tm_j | output | 1 | High-speed J test select |
| resume_req | output | 1 | Upstream resume request level |
| pullup_en | output | 1 | Device pull-up enable |

## Verification
The bench builds the block with its defaults, DATA_W=16 and EP_W=4, so the write port covers the four always-zero upper bits and endpoint numbers 1 to 15 show that the no-reply switch reaches only endpoint 0. Directed sequences hit the same-cycle collisions of SETUP against a no-reply write and of resume clears against a resume write; random traffic then mixes writes, tokens, endpoints and clear events with every rule's priority in play.

// File: rtl/usbd_ctrl_pkg.sv
package usbd_ctrl_pkg;

    localparam int BIT_DETACH  = 0;
    localparam int BIT_RESUME  = 1;
    localparam int SPD_LO      = 2;
    localparam int BIT_NOREPLY = 4;
    localparam int BIT_TSTJ    = 5;
    localparam int BIT_TSTK    = 6;
    localparam int BIT_TSTPKT  = 7;
    localparam int BIT_NOSTUFF = 8;
    localparam int BIT_GNAK    = 9;
    localparam int LPM_LO      = 10;
    localparam int USED_BITS   = 12;

    typedef enum logic [1:0] {
        TOK_SETUP = 2'd0,
        TOK_IN    = 2'd1,
        TOK_OUT   = 2'd2,
        TOK_LPM   = 2'd3
    } token_e;

    typedef enum logic [1:0] {
        HSK_NONE = 2'd0,
        HSK_ACK  = 2'd1,
        HSK_NAK  = 2'd2,
        HSK_NYET = 2'd3
    } hsk_e;

    typedef enum logic {
        RSM_IDLE   = 1'b0,
        RSM_SIGNAL = 1'b1
    } rsm_state_e;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_REPLY = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic [1:0] lpm_mode;
        logic       gnak;
        logic       nostuff;
        logic       tst_pkt;
        logic       tst_k;
        logic       tst_j;
        logic       no_reply;
        logic [1:0] speed;
        logic       detach;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{lpm_mode: 2'd0, gnak: 1'b0, nostuff: 1'b0,
                                     tst_pkt: 1'b0, tst_k: 1'b0, tst_j: 1'b0,
                                     no_reply: 1'b0, speed: 2'd0, detach: 1'b1};

endpackage

// File: rtl/usbd_ctrl_regs.sv
module usbd_ctrl_regs
    import usbd_ctrl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              setup_seen,
    output ctrl_t             cfg
);

    ctrl_t cfg_q, cfg_d, wr_view;

    always_comb begin
        wr_view.lpm_mode = wr_data[LPM_LO +: 2];
        wr_view.gnak     = wr_data[BIT_GNAK];
        wr_view.nostuff  = wr_data[BIT_NOSTUFF];
        wr_view.tst_pkt  = wr_data[BIT_TSTPKT];
        wr_view.tst_k    = wr_data[BIT_TSTK];
        wr_view.tst_j    = wr_data[BIT_TSTJ];
        wr_view.no_reply = wr_data[BIT_NOREPLY];
        wr_view.speed    = wr_data[SPD_LO +: 2];
        wr_view.detach   = wr_data[BIT_DETACH];
    end

    // hardware clear of the no-reply switch is applied after the write
    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d = wr_view;
        end
        if (setup_seen) begin
            cfg_d.no_reply = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CTRL_RESET;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/usbd_resume_fsm.sv
module usbd_resume_fsm
    import usbd_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic active
);

    rsm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSM_IDLE:   if (set_req && !clr_req) state_d = RSM_SIGNAL;
            RSM_SIGNAL: if (clr_req)             state_d = RSM_IDLE;
            default:                             state_d = RSM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        active = 1'b0;
        unique case (state_q)
            RSM_IDLE:   active = 1'b0;
            RSM_SIGNAL: active = 1'b1;
            default:    active = 1'b0;
        endcase
    end

endmodule

// File: rtl/usbd_hsk_arb.sv
module usbd_hsk_arb
    import usbd_ctrl_pkg::*;
#(
    parameter int EP_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            txn_valid,
    input  logic [1:0]      txn_token,
    input  logic [EP_W-1:0] txn_ep,
    input  logic            bank_ready,
    input  ctrl_t           cfg,
    output logic            hsk_valid,
    output logic [1:0]      hsk_code
);

    arb_state_e state_q, state_d;
    hsk_e       pick, code_q;
    token_e     tok;
    logic       ep0_silenced;

    assign tok          = token_e'(txn_token);
    assign ep0_silenced = cfg.no_reply && (txn_ep == '0) && (tok != TOK_SETUP);

    // priority: endpoint-0 silence, global NAK, LPM mode, bank status
    always_comb begin
        pick = HSK_NONE;
        if (ep0_silenced) begin
            pick = HSK_NONE;
        end else if (cfg.gnak) begin
            pick = HSK_NAK;
        end else if (tok == TOK_LPM) begin
            unique case (cfg.lpm_mode)
                2'd1:    pick = HSK_ACK;
                2'd2:    pick = HSK_NYET;
                default: pick = HSK_NONE;
            endcase
        end else begin
            pick = bank_ready ? HSK_ACK : HSK_NAK;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  state_d = txn_valid ? ARB_REPLY : ARB_IDLE;
            ARB_REPLY: state_d = txn_valid ? ARB_REPLY : ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            code_q  <= HSK_NONE;
        end else begin
            state_q <= state_d;
            if (txn_valid) begin
                code_q <= pick;
            end
        end
    end

    always_comb begin
        hsk_valid = 1'b0;
        hsk_code  = HSK_NONE;
        unique case (state_q)
            ARB_IDLE: begin
                hsk_valid = 1'b0;
                hsk_code  = HSK_NONE;
            end
            ARB_REPLY: begin
                hsk_valid = 1'b1;
                hsk_code  = code_q;
            end
            default: begin
                hsk_valid = 1'b0;
                hsk_code  = HSK_NONE;
            end
        endcase
    end

endmodule

// File: rtl/usbd_ctrl_hsk.sv
module usbd_ctrl_hsk
    import usbd_ctrl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int EP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              txn_valid,
    input  logic [1:0]        txn_token,
    input  logic [EP_W-1:0]   txn_ep,
    input  logic              bank_ready,
    input  logic              bus_reset,
    input  logic              resume_done,
    output logic              hsk_valid,
    output logic [1:0]        hsk_code,
    output logic [1:0]        speed_cfg,
    output logic              tm_nostuff,
    output logic              tm_packet,
    output logic              tm_k,
    output logic              tm_j,
    output logic              resume_req,
    output logic              pullup_en
);

    ctrl_t cfg;
    logic  setup_seen;
    logic  rsm_active;

    assign setup_seen = txn_valid && (token_e'(txn_token) == TOK_SETUP);

    usbd_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .setup_seen (setup_seen),
        .cfg        (cfg)
    );

    usbd_resume_fsm u_rsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (wr_en && wr_data[BIT_RESUME]),
        .clr_req (bus_reset || resume_done),
        .active  (rsm_active)
    );

    usbd_hsk_arb #(.EP_W(EP_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .txn_valid  (txn_valid),
        .txn_token  (txn_token),
        .txn_ep     (txn_ep),
        .bank_ready (bank_ready),
        .cfg        (cfg),
        .hsk_valid  (hsk_valid),
        .hsk_code   (hsk_code)
    );

    always_comb begin
        rd_data[0]               = cfg.detach;
        rd_data[BIT_RESUME]      = rsm_active;
        rd_data[SPD_LO +: 2]     = cfg.speed;
        rd_data[BIT_NOREPLY]     = cfg.no_reply;
        rd_data[BIT_TSTJ]        = cfg.tst_j;
        rd_data[BIT_TSTK]        = cfg.tst_k;
        rd_data[BIT_TSTPKT]      = cfg.tst_pkt;
        rd_data[BIT_NOSTUFF]     = cfg.nostuff;
        rd_data[BIT_GNAK]        = cfg.gnak;
        rd_data[LPM_LO +: 2]     = cfg.lpm_mode;
    end

    generate
        if (DATA_W > USED_BITS) begin : g_pad
            assign rd_data[DATA_W-1:USED_BITS] = '0;
        end
    endgenerate

    assign speed_cfg  = cfg.speed;
    assign tm_nostuff = cfg.nostuff;
    assign tm_packet  = cfg.tst_pkt;
    assign tm_k       = cfg.tst_k;
    assign tm_j       = cfg.tst_j;
    assign resume_req = rsm_active;
    assign pullup_en  = !cfg.detach;

endmodule

// File: rtl/usbd_ctrl_hsk_chk.sv
module usbd_ctrl_hsk_chk #(
    parameter int DATA_W = 16,
    parameter int EP_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              txn_valid,
    input logic [1:0]        txn_token,
    input logic [EP_W-1:0]   txn_ep,
    input logic              bank_ready,
    input logic              bus_reset,
    input logic              resume_done,
    input logic              hsk_valid,
    input logic [1:0]        hsk_code,
    input logic [1:0]        speed_cfg,
    input logic              tm_nostuff,
    input logic              tm_packet,
    input logic              tm_k,
    input logic              tm_j,
    input logic              resume_req,
    input logic              pullup_en
);

    logic silenced;
    assign silenced = rd_data[4] && (txn_ep == '0) && (txn_token != 2'd0);

    // R9
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> hsk_valid);

    // R9
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> !hsk_valid);

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:12] == '0);

    // R2
    field_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pullup_en == !rd_data[0]) && (speed_cfg == rd_data[3:2]) &&
        ({tm_nostuff, tm_packet, tm_k, tm_j} == rd_data[8:5]));

    // R3
    bank_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !silenced && !rd_data[9] && txn_token != 2'd3)
        |=> hsk_code == ($past(bank_ready) ? 2'd1 : 2'd2));

    // R4
    global_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !silenced && rd_data[9]) |=> hsk_code == 2'd2);

    // R5
    ep0_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && silenced) |=> hsk_code == 2'd0);

    // R6
    setup_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_token == 2'd0) |=> !rd_data[4]);

    // R8
    resume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset || resume_done) |=> !resume_req);

    // R8
    resume_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1] && !bus_reset && !resume_done) |=> resume_req);

    // R8
    resume_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_req && !bus_reset && !resume_done) |=> resume_req);

    // R8
    resume_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] == resume_req);

endmodule

bind usbd_ctrl_hsk usbd_ctrl_hsk_chk #(.DATA_W(DATA_W), .EP_W(EP_W)) u_chk (.*);

// File: tb/sim_usbd_ctrl_hsk.sv
`timescale 1ns/1ps
module sim_usbd_ctrl_hsk;

    localparam int DATA_W = 16;
    localparam int EP_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              txn_valid = 1'b0;
    logic [1:0]        txn_token = 2'd0;
    logic [EP_W-1:0]   txn_ep = '0;
    logic              bank_ready = 1'b0;
    logic              bus_reset = 1'b0;
    logic              resume_done = 1'b0;
    logic              hsk_valid;
    logic [1:0]        hsk_code;
    logic [1:0]        speed_cfg;
    logic              tm_nostuff, tm_packet, tm_k, tm_j;
    logic              resume_req, pullup_en;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [15:0] m_word;

    always #5 clk = ~clk;

    usbd_ctrl_hsk #(.DATA_W(DATA_W), .EP_W(EP_W)) u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] expect_hsk(input logic [15:0] w, input logic [1:0] tok,
                                              input logic [EP_W-1:0] ep, input logic br);
        if (w[4] && ep == '0 && tok != 2'd0) return 2'd0;
        if (w[9]) return 2'd2;
        if (tok == 2'd3) return (w[11:10] == 2'd1) ? 2'd1 : (w[11:10] == 2'd2) ? 2'd3 : 2'd0;
        return br ? 2'd1 : 2'd2;
    endfunction

    function automatic string hsk_tag(input logic [15:0] w, input logic [1:0] tok,
                                      input logic [EP_W-1:0] ep);
        if (w[4] && ep == '0 && tok != 2'd0) return "R5 ignore";
        if (w[9]) return "R4 global nak";
        if (tok == 2'd3) return "R7 lpm";
        if (w[4]) return "R5 other ep/setup";
        return "R3 bank";
    endfunction

    function automatic logic [15:0] next_word(input logic [15:0] w, input logic wr,
                                              input logic [15:0] wd, input logic setup,
                                              input logic clr);
        logic [15:0] n;
        n = w;
        if (wr) begin
            n = {4'h0, wd[11:2], w[1] | wd[1], wd[0]};
        end
        if (setup) n[4] = 1'b0;
        if (clr)   n[1] = 1'b0;
        return n;
    endfunction

    // drives one cycle at the falling edge, checks just after the rising edge
    task automatic cycle(input logic wr, input logic [15:0] wd, input logic tv,
                         input logic [1:0] tok, input logic [EP_W-1:0] ep,
                         input logic br, input logic brst, input logic rdn);
        logic [1:0]  exp_code;
        string       tag;
        wr_en = wr; wr_data = wd; txn_valid = tv; txn_token = tok;
        txn_ep = ep; bank_ready = br; bus_reset = brst; resume_done = rdn;
        exp_code = tv ? expect_hsk(m_word, tok, ep, br) : 2'd0;
        tag      = hsk_tag(m_word, tok, ep);
        m_word   = next_word(m_word, wr, wd, tv && tok == 2'd0, brst || rdn);
        @(posedge clk);
        #1;
        check("R9 hsk_valid", {31'd0, hsk_valid}, {31'd0, tv});
        if (tv) check(tag, {30'd0, hsk_code}, {30'd0, exp_code});
        check("R2/R6 read-back", {16'd0, rd_data}, {16'd0, m_word});
        check("R8 resume_req", {31'd0, resume_req}, {31'd0, m_word[1]});
        check("R2 pullup_en", {31'd0, pullup_en}, {31'd0, !m_word[0]});
        check("R2 test/speed", {26'd0, speed_cfg, tm_nostuff, tm_packet, tm_k, tm_j},
              {26'd0, m_word[3:2], m_word[8:5]});
        @(negedge clk);
    endtask

    task automatic wr_word(input logic [15:0] wd);
        cycle(1'b1, wd, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic txn(input logic [1:0] tok, input logic [EP_W-1:0] ep, input logic br);
        cycle(1'b0, 16'h0, 1'b1, tok, ep, br, 1'b0, 1'b0);
    endtask

    task automatic idle();
        cycle(1'b0, 16'h0, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        m_word = 16'h0001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 reset word", {16'd0, rd_data}, 32'h0001);
        check("R1 pullup_en", {31'd0, pullup_en}, 32'd0);
        check("R1 resume_req", {31'd0, resume_req}, 32'd0);
        check("R1 hsk_valid", {31'd0, hsk_valid}, 32'd0);
        idle();

        // R2 field load, upper bits ignored
        wr_word(16'hF000);
        wr_word(16'hA5AC);
        wr_word(16'h0000);
        // R3 normal answers, back-to-back
        txn(2'd1, 4'd0, 1'b1);
        txn(2'd2, 4'd3, 1'b0);
        txn(2'd0, 4'd0, 1'b0);
        // R7 LPM modes
        for (int m = 0; m < 4; m++) begin
            wr_word(16'(m << 10));
            txn(2'd3, 4'd2, 1'b1);
        end
        // R4 global NAK over bank and LPM
        wr_word(16'h0600);
        txn(2'd1, 4'd1, 1'b1);
        txn(2'd3, 4'd1, 1'b1);
        txn(2'd0, 4'd0, 1'b1);
        // R5 no-reply: ep0 silent, ep1 and SETUP normal, SETUP clears (R6)
        wr_word(16'h0010);
        txn(2'd1, 4'd0, 1'b1);
        txn(2'd2, 4'd0, 1'b1);
        txn(2'd3, 4'd0, 1'b1);
        txn(2'd1, 4'd15, 1'b1);
        txn(2'd0, 4'd0, 1'b1);
        txn(2'd1, 4'd0, 1'b1);
        // R5 with global NAK: silence first
        wr_word(16'h0210);
        txn(2'd2, 4'd0, 1'b0);
        // R6 SETUP beats write of no-reply in the same cycle
        cycle(1'b1, 16'h0010, 1'b1, 2'd0, 4'd5, 1'b1, 1'b0, 1'b0);
        // R8 resume set, hold, write 0 no effect, clear
        wr_word(16'h0002);
        idle();
        wr_word(16'h0000);
        cycle(1'b0, 16'h0, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b1);
        wr_word(16'h0002);
        cycle(1'b0, 16'h0, 1'b0, 2'd0, '0, 1'b0, 1'b1, 1'b0);
        // R8 clear beats simultaneous write
        cycle(1'b1, 16'h0002, 1'b0, 2'd0, '0, 1'b0, 1'b1, 1'b0);
        wr_word(16'h0002);
        cycle(1'b1, 16'h0002, 1'b0, 2'd0, '0, 1'b0, 1'b0, 1'b1);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic        wr, tv, br, brst, rdn;
            logic [15:0] wd;
            logic [1:0]  tok;
            logic [EP_W-1:0] ep;
            wr   = ($urandom % 6) == 0;
            wd   = 16'($urandom);
            tv   = ($urandom % 2) == 0;
            tok  = 2'($urandom);
            ep   = (($urandom % 3) == 0) ? '0 : EP_W'($urandom);
            br   = 1'($urandom);
            brst = ($urandom % 40) == 0;
            rdn  = ($urandom % 12) == 0;
            cycle(wr, wd, tv, tok, ep, br, brst, rdn);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule